// File: doc/BRIEF.md
# Dual Loop Counter Unit

This block holds two 16-bit iteration counters for a microcoded sequencer. Each counter sits at its own address on the A bus: microcode can load it from the bus or drive its value back onto the bus, independently of the other. When a loop counter is not needed, it works as a plain storage register.

A single select bit in the instruction word names the counter that loops use. That counter can be decremented in the same instruction as other work, and it can be tested for a conditional branch, either "is zero" or "is not zero". The select bit only steers the decrement and the test. Bus loads and bus reads always go to the counter that is addressed. A bus load and a decrement may hit the same counter in one instruction. The counter then holds the loaded value minus one.

The branch test looks at the selected counter as it stands at the start of the instruction, before that instruction's decrement takes effect. The sequencer and the branch-target logic are outside this block.

Top module: `loop_ctr_pair`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears both counters to 0x0000.
- R2: With `wr_c0` (or `wr_c1`) high at a rising edge and no decrement of that counter, the counter takes `bus_din`.
- R3: `bus_dout` is combinational. It shows counter 0 when `rd_c0` is high, otherwise counter 1 when `rd_c1` is high, otherwise 0x0000. Counter 0 wins when both read selects are high.
- R4: With `dec_req` high at a rising edge, the counter named by `ctr_sel` (0 selects counter 0, 1 selects counter 1) drops by one. The other counter is not changed. With `dec_req` low, no counter changes unless it is written.
- R5: `ctr_sel` has no effect on which counter a bus write loads or which counter a bus read shows.
- R6: When a counter is written and decremented at the same edge, its new value is `bus_din` minus one.
- R7: Decrementing a counter that holds 0x0000 gives 0xFFFF.
- R8: `branch_take` is 0 while `test_en` is low. With `test_en` high, `branch_take` is 1 when the selected counter equals zero (`test_ne` = 0) or does not equal zero (`test_ne` = 1).
- R9: `branch_take` depends on the selected counter's value before the decrement of the current cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_din | input | 16 | A bus data for counter writes |
| wr_c0 | input | 1 | Load counter 0 from bus_din |
| wr_c1 | input | 1 | Load counter 1 from bus_din |
| rd_c0 | input | 1 | Drive counter 0 onto bus_dout |
| rd_c1 | input | 1 | Drive counter 1 onto bus_dout |
| ctr_sel | input | 1 | Selects the counter for decrement and branch test (0 or 1) |
| dec_req | input | 1 | Decrement the selected counter |
| test_en | input | 1 | Enable the branch test |
| test_ne | input | 1 | Test type: 0 branches on zero, 1 branches on non-zero |
| bus_dout | output | 16 | A bus read data |
| branch_take | output | 1 | Branch condition |

## Verification
The assertions assume that every control input has a known value in each cycle after reset. They also assume that, within one cycle, a read on the bus and a test of the same counter both see the value the counter held before the edge. The stimulus changes inputs only at falling edges and holds them for a whole cycle. It sets both read selects together only where the read priority is the thing under test. It writes and decrements the same counter in one cycle only for the load-and-decrement cases.

// File: rtl/loop_ctr_pair.sv
module loop_ctr_pair #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] bus_din,
  input  logic         wr_c0,
  input  logic         wr_c1,
  input  logic         rd_c0,
  input  logic         rd_c1,
  input  logic         ctr_sel,
  input  logic         dec_req,
  input  logic         test_en,
  input  logic         test_ne,
  output logic [W-1:0] bus_dout,
  output logic         branch_take
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt0, cnt1;
  logic [W-1:0] base0, base1, sel_val;
  logic         dec0, dec1, is_zero;

  assign dec0  = dec_req & ~ctr_sel;
  assign dec1  = dec_req &  ctr_sel;
  assign base0 = wr_c0 ? bus_din : cnt0;
  assign base1 = wr_c1 ? bus_din : cnt1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt0 <= '0;
      cnt1 <= '0;
    end else begin
      cnt0 <= dec0 ? base0 - ONE : base0;
      cnt1 <= dec1 ? base1 - ONE : base1;
    end
  end

  assign bus_dout    = rd_c0 ? cnt0 : (rd_c1 ? cnt1 : '0);
  assign sel_val     = ctr_sel ? cnt1 : cnt0;
  assign is_zero     = (sel_val == '0);
  assign branch_take = test_en & (test_ne ? ~is_zero : is_zero);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $fell(rst) |-> (cnt0 == '0 && cnt1 == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_c0 && !dec0) |=> cnt0 == $past(bus_din));

  assert_idle_read_R3: assert property (@(posedge clk) disable iff (rst)
    (!rd_c0 && !rd_c1) |-> bus_dout == '0);

  assert_hold0_R4: assert property (@(posedge clk) disable iff (rst)
    (!wr_c0 && !dec0) |=> $stable(cnt0));

  assert_dec1_R4: assert property (@(posedge clk) disable iff (rst)
    (!wr_c1 && dec1) |=> cnt1 == $past(cnt1) - ONE);

  assert_wr_dec_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_c0 && dec0) |=> cnt0 == $past(bus_din) - ONE);

  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (!wr_c1 && dec1 && cnt1 == '0) |=> cnt1 == '1);

  assert_no_test_R8: assert property (@(posedge clk) disable iff (rst)
    !test_en |-> !branch_take);

endmodule

// File: tb/tb_loop_ctr_pair.sv
module tb_loop_ctr_pair;
  logic        clk = 0;
  logic        rst = 1;
  logic [15:0] bus_din = 0;
  logic wr_c0 = 0, wr_c1 = 0, rd_c0 = 0, rd_c1 = 0;
  logic ctr_sel = 0, dec_req = 0, test_en = 0, test_ne = 0;
  logic [15:0] bus_dout;
  logic        branch_take;

  loop_ctr_pair dut (.*);

  always #2 clk = ~clk;

  logic [15:0] m0 = 0, m1 = 0;
  logic [15:0] q_dout[$];
  logic        q_br[$];
  string       q_tag[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic step(input logic w0, w1, r0, r1, sel, dec, ten, tne,
                      input logic [15:0] din, input string tag);
    logic [15:0] sv, e_d, n0, n1;
    logic e_b;
    @(negedge clk);
    wr_c0 = w0; wr_c1 = w1; rd_c0 = r0; rd_c1 = r1;
    ctr_sel = sel; dec_req = dec; test_en = ten; test_ne = tne; bus_din = din;
    e_d = r0 ? m0 : (r1 ? m1 : 16'h0);
    sv  = sel ? m1 : m0;
    e_b = ten && (tne ? (sv != 0) : (sv == 0));
    q_dout.push_back(e_d); q_br.push_back(e_b); q_tag.push_back(tag);
    n0 = w0 ? din : m0;
    n1 = w1 ? din : m1;
    if (dec && !sel) n0 = n0 - 16'd1;
    if (dec &&  sel) n1 = n1 - 16'd1;
    m0 = n0; m1 = n1;
  endtask

  task automatic rd(input logic which, input logic sel, input string tag);
    step(0, 0, !which, which, sel, 0, 0, 0, 16'h0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; wr_c0 = 0; wr_c1 = 0; dec_req = 0; test_en = 0;
    repeat (2) @(negedge clk);
    rst = 0; m0 = 0; m1 = 0;
  endtask

  always @(negedge clk) begin
    #1;
    if (q_dout.size() > 0) begin
      logic [15:0] ed; logic eb; string t;
      ed = q_dout.pop_front(); eb = q_br.pop_front(); t = q_tag.pop_front();
      checks++;
      if (bus_dout !== ed || branch_take !== eb) begin
        fails++;
        $display("FAIL %s: dout=%h br=%b expected dout=%h br=%b",
                 t, bus_dout, branch_take, ed, eb);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    rd(0, 0, "R1"); rd(1, 0, "R1");
    step(1, 0, 0, 0, 1, 0, 0, 0, 16'h1234, "R2");
    rd(0, 1, "R2");
    step(0, 1, 0, 0, 0, 0, 0, 0, 16'h00A5, "R5");
    rd(1, 0, "R5"); rd(0, 1, "R5");
    step(0, 0, 1, 1, 0, 0, 0, 0, 16'h0, "R3");
    step(0, 0, 0, 0, 0, 0, 0, 0, 16'h0, "R3");
    step(0, 0, 0, 0, 0, 1, 0, 0, 16'h0, "R4");
    rd(0, 0, "R4"); rd(1, 0, "R4");
    step(0, 0, 0, 1, 1, 1, 0, 0, 16'h0, "R4");
    rd(1, 1, "R4"); rd(0, 1, "R4");
    step(1, 0, 0, 0, 0, 1, 0, 0, 16'h0010, "R6");
    rd(0, 0, "R6");
    step(0, 1, 0, 0, 0, 1, 0, 0, 16'h0500, "R4");
    rd(0, 0, "R4"); rd(1, 0, "R4");
    step(0, 1, 0, 0, 1, 1, 0, 0, 16'h0000, "R6");
    rd(1, 0, "R6");
    step(0, 1, 0, 0, 0, 0, 0, 0, 16'h0000, "R7");
    step(0, 0, 0, 0, 1, 1, 0, 0, 16'h0, "R7");
    rd(1, 0, "R7");
    step(1, 0, 0, 0, 0, 0, 0, 0, 16'h0001, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 0, 16'h0, "R8");
    step(0, 0, 0, 0, 0, 0, 1, 1, 16'h0, "R8");
    step(0, 0, 0, 0, 1, 0, 1, 1, 16'h0, "R8");
    step(0, 0, 0, 0, 0, 1, 1, 0, 16'h0, "R9");
    step(0, 0, 1, 0, 0, 0, 1, 0, 16'h0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, 16'h0, "R8");
    step(1, 0, 0, 0, 0, 1, 0, 0, 16'h0000, "R7");
    rd(0, 0, "R7");
    do_reset();
    rd(0, 0, "R1"); rd(1, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 16'h0, "R1");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule